// File: doc/BRIEF.md
# I2C Serial Memory Slave Engine

This block is the bus-facing half of a 128-byte serial memory that answers on a two-wire I2C bus. It runs on a fast system clock and oversamples the bus clock and data lines. From those samples it finds START, repeated START and STOP conditions and shifts in bytes with the most significant bit first. It checks the device select byte against a fixed 1010 device code followed by three strap inputs. It acknowledges bytes and sends read data by driving a single open-drain pull-down enable. It never drives the data line high.

The engine holds the memory's byte pointer. It runs the current-address, random-address and sequential read modes, and the pointer wraps from the last location back to zero. Each written data byte goes to a separate write controller as a one-cycle strobe with its address and value. A STOP that closes a write is passed on as a commit pulse. While the controller reports busy, the engine does not acknowledge its device select byte, so a bus master can poll for the end of the programming cycle. Read data comes back from the controller through an address/data port. The engine samples that port only on an SCL falling edge, long after the address settled.

Top module: `i2c_mem_slave_engine`

## Requirements
- R1: The first byte after a START is compared MSB first against the pattern 1,0,1,0,strap_i[2],strap_i[1],strap_i[0], and bit 0 is the direction (1 = read, 0 = write). On an exact match of those seven bits the engine pulls SDA low in the 9th clock. On a mismatch it stays silent and ignores the bus until the next START.
- R2: SDA falling while SCL is high is a START, and SDA rising while SCL is high is a STOP. Before any START, bus traffic gets no response. A STOP releases SDA and returns the engine to standby.
- R3: The byte after a write device select is the address byte, and it is acknowledged. Its low 7 bits load the byte pointer, and bit 7 is ignored.
- R4: Each following data byte of a write is acknowledged. One cycle after its 8th rising SCL edge, wr_en_o pulses for one cycle with wr_addr_o equal to the pointer and wr_data_o equal to the byte. The pointer then steps up by one, modulo 128.
- R5: A STOP that ends a write containing at least one data byte gives one wr_commit_o pulse. A STOP after only a device select, or only an address byte, gives none.
- R6: A read device select sent without a preceding address returns the byte at the pointer. The pointer then steps up by one.
- R7: A random read is a write device select, an address byte, a repeated START and then a read device select. It returns the byte at the loaded address.
- R8: While the master acknowledges each read byte, bytes from consecutive addresses follow, and after address 127 the next byte comes from address 0.
- R9: If the master leaves SDA high in the 9th clock of a read byte, the engine releases SDA and answers nothing until the next START.
- R10: While busy_i is high when the device select byte completes, that byte is not acknowledged.
- R11: sda_oe_o becomes asserted only while the synchronized SCL is low.
- R12: After reset, sda_oe_o, wr_en_o and wr_commit_o are low and rd_addr_o is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Bus clock line as seen at the pin |
| sda_i | input | 1 | Bus data line as seen at the pin |
| strap_i | input | 3 | Board strap bits that complete the device address |
| busy_i | input | 1 | Write controller is programming; device select is not acknowledged |
| rd_data_i | input | 8 | Byte stored at rd_addr_o |
| sda_oe_o | output | 1 | Pull SDA low when high |
| rd_addr_o | output | 7 | Current byte pointer, used as the read address |
| wr_en_o | output | 1 | One-cycle strobe for a received data byte |
| wr_addr_o | output | 7 | Location for the strobed byte |
| wr_data_o | output | 8 | Strobed data byte |
| wr_commit_o | output | 1 | One-cycle pulse on STOP closing a write with data |

## Verification
The in-RTL properties check on every cycle that the pull-down only ever switches on while the synchronized clock is low, and that a STOP always lands the engine in standby with the line released. They also check that a completed device select seen under busy never leaves an acknowledge pending, that write strobes only leave the data phase, that commits only come out in standby, and that each pointer step adds exactly one modulo the array size. Only the bench scenarios can show the byte-level results. These are the address match and mismatch, the ignored address MSB, the read modes returning the right bytes, the wrap from 127 to 0, busy polling, and silence after a NACK or before any START.

// File: rtl/i2cm_pkg.sv
package i2cm_pkg;
  localparam int BYTE_W = 8;
  localparam logic [3:0] DEV_CODE = 4'b1010;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_DEV,
    PH_ADDR,
    PH_WR,
    PH_RD
  } phase_t;
endpackage

// File: rtl/i2cm_line_sync.sv
module i2cm_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_lvl,
  output logic sda_lvl,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_ev,
  output logic stop_ev
);
  logic [STAGES-1:0] scl_ff, sda_ff;
  logic scl_q, sda_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_ff <= '1;
      sda_ff <= '1;
      scl_q  <= 1'b1;
      sda_q  <= 1'b1;
    end else begin
      scl_ff <= {scl_ff[STAGES-2:0], scl_i};
      sda_ff <= {sda_ff[STAGES-2:0], sda_i};
      scl_q  <= scl_ff[STAGES-1];
      sda_q  <= sda_ff[STAGES-1];
    end
  end

  assign scl_lvl  = scl_ff[STAGES-1];
  assign sda_lvl  = sda_ff[STAGES-1];
  assign scl_rise = scl_lvl & ~scl_q;
  assign scl_fall = ~scl_lvl & scl_q;
  assign start_ev = scl_lvl & scl_q & sda_q & ~sda_lvl;
  assign stop_ev  = scl_lvl & scl_q & ~sda_q & sda_lvl;
endmodule

// File: rtl/i2cm_addr_ctr.sv
module i2cm_addr_ctr #(
  parameter int AW = 7
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [AW-1:0] load_val,
  input  logic          inc,
  output logic [AW-1:0] ptr
);
  always_ff @(posedge clk) begin
    if (rst)       ptr <= '0;
    else if (load) ptr <= load_val;
    else if (inc)  ptr <= ptr + AW'(1);
  end

  // R8: each step advances by exactly one and wraps at the array end
  p_ptr_step_r8: assert property (@(posedge clk) disable iff (rst)
    (inc && !load) |=> (ptr == $past(ptr) + AW'(1)));
endmodule

// File: rtl/i2cm_proto.sv
module i2cm_proto
  import i2cm_pkg::*;
#(
  parameter int AW = 7
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              scl_lvl,
  input  logic              sda_lvl,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              start_ev,
  input  logic              stop_ev,
  input  logic [2:0]        strap,
  input  logic              busy,
  input  logic [BYTE_W-1:0] rd_data,
  input  logic [AW-1:0]     ptr,
  output logic              sda_oe,
  output logic              ptr_load,
  output logic [AW-1:0]     ptr_load_val,
  output logic              ptr_inc,
  output logic              wr_en,
  output logic [AW-1:0]     wr_addr,
  output logic [BYTE_W-1:0] wr_data,
  output logic              wr_commit
);
  localparam int CW = $clog2(BYTE_W + 2);
  localparam logic [CW-1:0] LAST_BIT = CW'(BYTE_W - 1);
  localparam logic [CW-1:0] ACK_SLOT = CW'(BYTE_W);
  localparam logic [CW-1:0] ACK_DONE = CW'(BYTE_W + 1);

  phase_t            ph;
  logic [CW-1:0]     cnt;
  logic [BYTE_W-1:0] shreg, txreg;
  logic              ack_pend, rw, wr_any, m_ack;
  logic [BYTE_W-1:0] byte_in;

  assign byte_in = {shreg[BYTE_W-2:0], sda_lvl};

  always_ff @(posedge clk) begin
    if (rst) begin
      ph <= PH_IDLE; cnt <= '0; shreg <= '0; txreg <= '0;
      ack_pend <= 1'b0; rw <= 1'b0; wr_any <= 1'b0; m_ack <= 1'b0;
      sda_oe <= 1'b0; ptr_load <= 1'b0; ptr_load_val <= '0; ptr_inc <= 1'b0;
      wr_en <= 1'b0; wr_addr <= '0; wr_data <= '0; wr_commit <= 1'b0;
    end else begin
      ptr_load  <= 1'b0;
      ptr_inc   <= 1'b0;
      wr_en     <= 1'b0;
      wr_commit <= 1'b0;
      if (stop_ev) begin
        if (wr_any && ph == PH_WR) wr_commit <= 1'b1;
        ph <= PH_IDLE; sda_oe <= 1'b0; cnt <= '0; wr_any <= 1'b0;
      end else if (start_ev) begin
        ph <= PH_DEV; sda_oe <= 1'b0; cnt <= '0; wr_any <= 1'b0;
      end else begin
        case (ph)
          PH_DEV, PH_ADDR, PH_WR: begin
            if (scl_rise) begin
              if (cnt < ACK_SLOT) begin
                shreg <= byte_in;
                cnt   <= cnt + 1'b1;
                if (cnt == LAST_BIT) begin
                  case (ph)
                    PH_DEV: begin
                      ack_pend <= (byte_in[BYTE_W-1:1] == {DEV_CODE, strap}) && !busy;
                      rw       <= byte_in[0];
                    end
                    PH_ADDR: begin
                      ack_pend     <= 1'b1;
                      ptr_load     <= 1'b1;
                      ptr_load_val <= byte_in[AW-1:0];
                    end
                    default: begin
                      ack_pend <= 1'b1;
                      wr_en    <= 1'b1;
                      wr_addr  <= ptr;
                      wr_data  <= byte_in;
                      ptr_inc  <= 1'b1;
                      wr_any   <= 1'b1;
                    end
                  endcase
                end
              end else begin
                cnt <= ACK_DONE;
              end
            end else if (scl_fall) begin
              if (cnt == ACK_SLOT) begin
                sda_oe <= ack_pend;
                if (!ack_pend) begin
                  ph  <= PH_IDLE;
                  cnt <= '0;
                end
              end else if (cnt == ACK_DONE) begin
                cnt <= '0;
                if (ph == PH_DEV && rw) begin
                  ph      <= PH_RD;
                  txreg   <= rd_data;
                  sda_oe  <= ~rd_data[BYTE_W-1];
                  ptr_inc <= 1'b1;
                end else begin
                  sda_oe <= 1'b0;
                  ph     <= (ph == PH_DEV) ? PH_ADDR : PH_WR;
                end
              end
            end
          end
          PH_RD: begin
            if (scl_rise) begin
              if (cnt < ACK_SLOT) cnt <= cnt + 1'b1;
              else begin
                cnt   <= ACK_DONE;
                m_ack <= ~sda_lvl;
              end
            end else if (scl_fall) begin
              if (cnt != '0 && cnt < ACK_SLOT) begin
                txreg  <= {txreg[BYTE_W-2:0], 1'b0};
                sda_oe <= ~txreg[BYTE_W-2];
              end else if (cnt == ACK_SLOT) begin
                sda_oe <= 1'b0;
              end else if (cnt == ACK_DONE) begin
                cnt <= '0;
                if (m_ack) begin
                  txreg   <= rd_data;
                  sda_oe  <= ~rd_data[BYTE_W-1];
                  ptr_inc <= 1'b1;
                end else begin
                  ph     <= PH_IDLE;
                  sda_oe <= 1'b0;
                end
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

  // R11: the pull-down only switches on while the bus clock is low
  p_oe_rise_scl_low_r11: assert property (@(posedge clk) disable iff (rst)
    $rose(sda_oe) |-> !scl_lvl);
  // R2: a STOP leaves the engine in standby with SDA released
  p_stop_idle_r2: assert property (@(posedge clk) disable iff (rst)
    stop_ev |=> (ph == PH_IDLE && !sda_oe));
  // R10: a device select completed under busy never leaves an acknowledge pending
  p_busy_nack_r10: assert property (@(posedge clk) disable iff (rst)
    (ph == PH_DEV && scl_rise && !start_ev && !stop_ev && cnt == LAST_BIT && busy) |=> !ack_pend);
  // R4: write strobes come only out of the data phase
  p_wr_from_data_r4: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> ($past(ph) == PH_WR));
  // R5: commits appear only once the engine is back in standby
  p_commit_idle_r5: assert property (@(posedge clk) disable iff (rst)
    wr_commit |-> (ph == PH_IDLE));
endmodule

// File: rtl/i2c_mem_slave_engine.sv
module i2c_mem_slave_engine
  import i2cm_pkg::*;
#(
  parameter int AW          = 7,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              scl_i,
  input  logic              sda_i,
  input  logic [2:0]        strap_i,
  input  logic              busy_i,
  input  logic [BYTE_W-1:0] rd_data_i,
  output logic              sda_oe_o,
  output logic [AW-1:0]     rd_addr_o,
  output logic              wr_en_o,
  output logic [AW-1:0]     wr_addr_o,
  output logic [BYTE_W-1:0] wr_data_o,
  output logic              wr_commit_o
);
  logic scl_lvl, sda_lvl, scl_rise, scl_fall, start_ev, stop_ev;
  logic ptr_load, ptr_inc;
  logic [AW-1:0] ptr_load_val, ptr;

  i2cm_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .scl_i(scl_i), .sda_i(sda_i),
    .scl_lvl(scl_lvl), .sda_lvl(sda_lvl), .scl_rise(scl_rise),
    .scl_fall(scl_fall), .start_ev(start_ev), .stop_ev(stop_ev)
  );

  i2cm_addr_ctr #(.AW(AW)) u_ptr (
    .clk(clk), .rst(rst), .load(ptr_load), .load_val(ptr_load_val),
    .inc(ptr_inc), .ptr(ptr)
  );

  i2cm_proto #(.AW(AW)) u_proto (
    .clk(clk), .rst(rst), .scl_lvl(scl_lvl), .sda_lvl(sda_lvl),
    .scl_rise(scl_rise), .scl_fall(scl_fall), .start_ev(start_ev),
    .stop_ev(stop_ev), .strap(strap_i), .busy(busy_i), .rd_data(rd_data_i),
    .ptr(ptr), .sda_oe(sda_oe_o), .ptr_load(ptr_load),
    .ptr_load_val(ptr_load_val), .ptr_inc(ptr_inc), .wr_en(wr_en_o),
    .wr_addr(wr_addr_o), .wr_data(wr_data_o), .wr_commit(wr_commit_o)
  );

  assign rd_addr_o = ptr;
endmodule

// File: tb/test_i2c_mem_slave_engine.sv
module test_i2c_mem_slave_engine;
  localparam int T = 10;
  localparam int BUSY_CLKS = 1000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic scl = 1'b1;
  logic sda_m = 1'b1;
  logic [2:0] strap = 3'b101;
  logic busy = 1'b0;
  logic [7:0] rd_data;
  logic sda_oe, wr_en, wr_commit;
  logic [6:0] rd_addr, wr_addr;
  logic [7:0] wr_data;
  logic sda_bus;

  int n_chk = 0, n_fail = 0, commits = 0, busy_cnt = 0;
  int viol_scl = 0, viol_quiet = 0;
  bit quiet = 1'b0, done = 1'b0;
  logic prev_oe = 1'b0;
  logic [7:0] mem [128];
  logic [14:0] got_q[$];

  always #5 clk = ~clk;

  assign sda_bus = sda_m & ~sda_oe;
  always_comb rd_data = mem[rd_addr];

  i2c_mem_slave_engine i_i2c_mem_slave_engine (
    .clk(clk), .rst(rst), .scl_i(scl), .sda_i(sda_bus), .strap_i(strap),
    .busy_i(busy), .rd_data_i(rd_data), .sda_oe_o(sda_oe), .rd_addr_o(rd_addr),
    .wr_en_o(wr_en), .wr_addr_o(wr_addr), .wr_data_o(wr_data),
    .wr_commit_o(wr_commit)
  );

  // write controller stand-in and per-clock monitors
  initial for (int i = 0; i < 128; i++) mem[i] = 8'(i * 5 + 3);

  always @(posedge clk) begin
    if (!rst) begin
      if (wr_en) begin
        got_q.push_back({wr_addr, wr_data});
        mem[wr_addr] <= wr_data;
      end
      if (wr_commit) begin
        commits++;
        busy_cnt = BUSY_CLKS;
      end else if (busy_cnt > 0) begin
        busy_cnt--;
      end
      busy <= (busy_cnt > 0);
    end
  end

  always @(negedge clk) begin
    if (sda_oe && !prev_oe && scl) viol_scl++;
    if (quiet && sda_oe) viol_quiet++;
    prev_oe = sda_oe;
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic do_start;
    sda_m = 1'b1; tick(T); scl = 1'b1; tick(T); sda_m = 1'b0; tick(T); scl = 1'b0; tick(T);
  endtask

  task automatic do_stop;
    sda_m = 1'b0; tick(T); scl = 1'b1; tick(T); sda_m = 1'b1; tick(2 * T);
  endtask

  task automatic send_byte(input logic [7:0] v, output bit ack);
    for (int i = 7; i >= 0; i--) begin
      sda_m = v[i]; tick(T); scl = 1'b1; tick(2 * T); scl = 1'b0; tick(T);
    end
    sda_m = 1'b1; tick(T); scl = 1'b1; tick(T); ack = !sda_bus; tick(T); scl = 1'b0; tick(T);
  endtask

  task automatic recv_byte(output logic [7:0] v, input bit give_ack);
    for (int i = 7; i >= 0; i--) begin
      sda_m = 1'b1; tick(T); scl = 1'b1; tick(T); v[i] = sda_bus; tick(T); scl = 1'b0; tick(T);
    end
    sda_m = !give_ack; tick(T); scl = 1'b1; tick(2 * T); scl = 1'b0; tick(T);
    sda_m = 1'b1;
  endtask

  initial begin
    bit a;
    logic [7:0] d;
    tick(5);
    rst = 1'b0;
    tick(2);
    // R12: reset state
    chk(!sda_oe && !wr_en && !wr_commit, "R12 outputs idle", {sda_oe, wr_en, wr_commit}, 0);
    chk(rd_addr == 7'd0, "R12 pointer", rd_addr, 0);

    // R2: traffic before any START is ignored
    quiet = 1'b1;
    send_byte(8'hAA, a);
    quiet = 1'b0;
    chk(!a, "R2 no ack before START", a, 0);

    // R1, R3, R4: write 0x85 -> location 5, three bytes
    do_start;
    send_byte(8'hAA, a); chk(a, "R1 devsel match ack", a, 1);
    send_byte(8'h85, a); chk(a, "R3 address ack", a, 1);
    send_byte(8'h11, a); chk(a, "R4 data ack 0", a, 1);
    send_byte(8'h22, a); chk(a, "R4 data ack 1", a, 1);
    send_byte(8'h33, a); chk(a, "R4 data ack 2", a, 1);
    do_stop;
    chk(commits == 1, "R5 commit after write", commits, 1);
    chk(got_q.size() == 3, "R4 strobe count", got_q.size(), 3);
    if (got_q.size() == 3) begin
      chk(got_q[0] == {7'd5, 8'h11}, "R3 top bit ignored, first strobe", got_q[0], {7'd5, 8'h11});
      chk(got_q[1] == {7'd6, 8'h22}, "R4 second strobe", got_q[1], {7'd6, 8'h22});
      chk(got_q[2] == {7'd7, 8'h33}, "R4 third strobe", got_q[2], {7'd7, 8'h33});
    end

    // R10: polling while busy
    do_start;
    send_byte(8'hAA, a); chk(!a, "R10 no ack while busy", a, 0);
    do_stop;
    tick(BUSY_CLKS + 100);
    do_start;
    send_byte(8'hAA, a); chk(a, "R10 ack once idle", a, 1);
    do_stop;
    chk(commits == 1, "R5 no commit after select only", commits, 1);

    // R1: strap mismatch, then R2 rest ignored without START
    do_start;
    quiet = 1'b1;
    send_byte(8'hA2, a); chk(!a, "R1 wrong strap no ack", a, 0);
    send_byte(8'hAA, a); chk(!a, "R1 silent until START", a, 0);
    quiet = 1'b0;
    do_stop;

    // R7, R8: random read at 5, sequential
    do_start;
    send_byte(8'hAA, a);
    send_byte(8'h05, a);
    do_start;
    send_byte(8'hAB, a); chk(a, "R7 read select ack", a, 1);
    recv_byte(d, 1'b1); chk(d == 8'h11, "R7 random read", d, 8'h11);
    recv_byte(d, 1'b1); chk(d == 8'h22, "R8 sequential 1", d, 8'h22);
    recv_byte(d, 1'b0); chk(d == 8'h33, "R8 sequential 2", d, 8'h33);
    tick(4);
    chk(!sda_oe, "R9 released after nack", sda_oe, 0);
    quiet = 1'b1;
    send_byte(8'hAB, a); chk(!a, "R9 silent after nack", a, 0);
    quiet = 1'b0;
    do_stop;
    chk(commits == 1, "R5 no commit after dummy write", commits, 1);

    // R6: current address reads
    do_start;
    send_byte(8'hAB, a);
    recv_byte(d, 1'b0); chk(d == 8'h2B, "R6 current read", d, 8'h2B);
    do_stop;
    do_start;
    send_byte(8'hAB, a);
    recv_byte(d, 1'b0); chk(d == 8'h30, "R6 pointer stepped", d, 8'h30);
    do_stop;

    // R8: wrap 127 -> 0
    do_start;
    send_byte(8'hAA, a);
    send_byte(8'h7F, a);
    do_start;
    send_byte(8'hAB, a);
    recv_byte(d, 1'b1); chk(d == 8'h7E, "R8 last location", d, 8'h7E);
    recv_byte(d, 1'b0); chk(d == 8'h03, "R8 wrap to 0", d, 8'h03);
    do_stop;

    chk(viol_scl == 0, "R11 pull-down only with SCL low", viol_scl, 0);
    chk(viol_quiet == 0, "R2 R9 no drive while ignored", viol_quiet, 0);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #(200000 * 10);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule